// File: doc/BRIEF.md
# Shared enable/status interrupt gatherer

This block gathers a small group of interrupt sources into one level-sensitive request line for a parent interrupt controller. Every source event is caught on a rising edge of its input and kept in a status flag until software clears it. Software controls the whole block through a single 32-bit register on a simple register port. The lower half holds one enable bit per source. The upper half holds the matching status flags, each exactly 16 positions above its enable. Status flags are cleared by writing 1.

Two parameters place the sources inside each half: how many there are, and the bit position of the first one. Since a status flag clears only when written with 1, one write can update every enable without touching pending status. Masking a source means clearing its enable and unmasking means setting it. Neither action alters a status flag. The request line stays high while any source has both its status and its enable set. It falls only once each such flag is cleared or masked.

Top module: `irq_gather`

## Requirements
- R1: The register responds only at address `REG_OFS`. `bus_rdata` returns its current value in the same cycle, combinationally from `bus_addr`. Any other address reads as 0 and writes to it are ignored.
- R2: For source i (0 ≤ i < `NUM_SRC`), the enable sits at register bit `SRC_LSB+i` and the status flag at bit `16+SRC_LSB+i`.
- R3: A write that puts 1 in a status bit clears that flag at the next clock edge. Writing 0 to a status bit leaves it unchanged.
- R4: Enable bits are plain read/write storage. A write that changes enables leaves every status flag as it was.
- R5: `irq_o` is high exactly when at least one source has both its status and its enable set. While it is high and no register write occurs, it stays high.
- R6: A 0-to-1 transition of `src_i[i]`, seen at a clock edge, sets status flag i whatever its enable. A source held high does not set the flag again after it is cleared.
- R7: If a new event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: Register bits outside both source fields read as 0, and writes to them have no effect.
- R9: After reset, all enables and status flags are 0 and `irq_o` is low. The previous-value sample of each source resets to 0, so a source already high when reset is released counts as an event.
- R10: `bus_be[k]` gates write data bits [8k+7:8k]. A byte whose strobe is 0 changes neither enables nor status flags.
- R11: `NUM_SRC` must be at least 1 and `SRC_LSB+NUM_SRC` must not exceed 16. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Source event inputs, rising edge detected |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes for write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Level-sensitive summary interrupt |

## Verification
Each stored bit of this block reaches the ports combinationally, through `bus_rdata` and through `irq_o`. A wrong flag or enable bit therefore shows up in the first cycle after the clock edge that stored it. The bench holds the read address on the register and compares the full register word and the request line on every cycle against its own model. A dropped edge, a lost clear, a clear gated by the wrong strobe, or a bit written outside the field all show up one cycle after the stimulus that should have produced them.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
   localparam int REG_W   = 32;
   localparam int HALF_W  = 16;
   localparam int BYTES_W = REG_W / 8;
   typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/irqg_src_cell.sv
module irqg_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic en_we_i,
   input  logic en_wd_i,
   input  logic clr_i,
   output logic en_o,
   output logic st_o
);
   logic src_q;
   logic en_q;
   logic st_q;
   logic rise;

   assign rise = src_i & ~src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         en_q  <= 1'b0;
         st_q  <= 1'b0;
      end else begin
         src_q <= src_i;
         if (en_we_i) en_q <= en_wd_i;
         if (rise)       st_q <= 1'b1;
         else if (clr_i) st_q <= 1'b0;
      end
   end

   assign en_o = en_q;
   assign st_o = st_q;

   // status holds unless a 1 is written to it
   assert_status_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q && !clr_i) |=> st_q);

   // event beats a same-cycle clear
   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && clr_i) |=> st_q);

   // enable changes only through its own write
   assert_enable_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we_i |=> $stable(en_q));

   // a seen edge always leaves the flag set
   assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> st_q);
endmodule

// File: rtl/irqg_summary.sv
module irqg_summary #(
   parameter int NUM_SRC = 7
) (
   input  logic [NUM_SRC-1:0] st_i,
   input  logic [NUM_SRC-1:0] en_i,
   output logic               irq_o
);
   assign irq_o = |(st_i & en_i);
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
   parameter int          NUM_SRC = 7,
   parameter int          SRC_LSB = 0,
   parameter int          ADDR_W  = 8,
   parameter int unsigned REG_OFS = 32'h18
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    src_i,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [31:0]           bus_wdata,
   input  logic [3:0]            bus_be,
   output logic [31:0]           bus_rdata,
   output logic                  irq_o
);
   import irqg_pkg::*;

   localparam logic [ADDR_W-1:0] OFS_A = ADDR_W'(REG_OFS);

   // R11: elaboration-time parameter checks
   if (NUM_SRC < 1) begin : g_bad_count
      $error("irq_gather: NUM_SRC must be at least 1");
   end
   if (SRC_LSB < 0 || SRC_LSB + NUM_SRC > HALF_W) begin : g_bad_field
      $error("irq_gather: source field exceeds the enable half");
   end

   logic              hit_wr;
   logic [NUM_SRC-1:0] en_vec;
   logic [NUM_SRC-1:0] st_vec;
   reg_word_t         reg_val;

   assign hit_wr = bus_we && (bus_addr == OFS_A);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int EB = SRC_LSB + i;
      localparam int SB = HALF_W + EB;
      logic en_we;
      logic clr;
      assign en_we = hit_wr && bus_be[EB/8];
      assign clr   = hit_wr && bus_be[SB/8] && bus_wdata[SB];
      irqg_src_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_i   (src_i[i]),
         .en_we_i (en_we),
         .en_wd_i (bus_wdata[EB]),
         .clr_i   (clr),
         .en_o    (en_vec[i]),
         .st_o    (st_vec[i])
      );
   end

   always_comb begin
      reg_val = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         reg_val[SRC_LSB + i]          = en_vec[i];
         reg_val[HALF_W + SRC_LSB + i] = st_vec[i];
      end
   end

   assign bus_rdata = (bus_addr == OFS_A) ? reg_val : '0;

   irqg_summary #(.NUM_SRC(NUM_SRC)) u_sum (
      .st_i  (st_vec),
      .en_i  (en_vec),
      .irq_o (irq_o)
   );

   // level output cannot drop without a register write
   assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !hit_wr) |=> irq_o);

   // writes elsewhere leave the register untouched
   assert_other_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr != OFS_A && src_i == '0) |=> $stable(reg_val));
endmodule

// File: tb/irq_gather_bench.sv
module irq_gather_bench;
   localparam int N   = 2;
   localparam int L   = 4;
   localparam int AW  = 8;
   localparam int OFS = 32'h18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src = '0;
   logic [AW-1:0] addr = AW'(OFS);
   logic          we = 1'b0;
   logic [31:0]   wd = '0;
   logic [3:0]    be = '0;
   logic [31:0]   rdata;
   logic          irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;
   string cur_req = "R9";

   int m_en[N];
   int m_st[N];
   int m_prev[N];

   always #5 clk = ~clk;

   irq_gather #(.NUM_SRC(N), .SRC_LSB(L), .ADDR_W(AW), .REG_OFS(OFS)) u_irq_gather (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wd), .bus_be(be), .bus_rdata(rdata), .irq_o(irq)
   );

   function automatic logic [31:0] model_reg();
      logic [31:0] v = '0;
      for (int i = 0; i < N; i++) begin
         v[L+i]    = m_en[i][0];
         v[16+L+i] = m_st[i][0];
      end
      return v;
   endfunction

   function automatic logic model_irq();
      for (int i = 0; i < N; i++) if (m_en[i] != 0 && m_st[i] != 0) return 1'b1;
      return 1'b0;
   endfunction

   task automatic model_step();
      bit wr = we && (addr == AW'(OFS));
      for (int i = 0; i < N; i++) begin
         int eb = L + i;
         int sb = 16 + L + i;
         bit rise = src[i] && (m_prev[i] == 0);
         bit clr  = wr && be[sb/8] && wd[sb];
         if (wr && be[eb/8]) m_en[i] = wd[eb];
         if (rise) m_st[i] = 1;
         else if (clr) m_st[i] = 0;
         m_prev[i] = src[i];
      end
   endtask

   task automatic compare();
      logic [31:0] exp_r = (addr == AW'(OFS)) ? model_reg() : 32'h0;
      logic exp_i = model_irq();
      vectors++;
      if (rdata !== exp_r) begin
         errors++;
         $display("FAIL %s rdata actual=%h expected=%h", cur_req, rdata, exp_r);
      end
      if (irq !== exp_i) begin
         errors++;
         $display("FAIL R5 irq_o actual=%b expected=%b (phase %s)", irq, exp_i, cur_req);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      we = 1'b0; wd = '0; be = '0;
   endtask

   task automatic wr_reg(input logic [31:0] d, input logic [3:0] b);
      we = 1'b1; wd = d; be = b;
      tick();
      idle();
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_st[i] = 0; m_prev[i] = 0; end
      repeat (3) @(negedge clk);
      cur_req = "R9";
      compare();
      rst_n = 1'b1;
      tick();

      // R6: edge sets status while disabled, irq stays low (R5)
      cur_req = "R6";
      src = 2'b01; tick();
      src = 2'b00; tick();

      // R4 / R2: enable bit 4 and 5 without touching status
      cur_req = "R4";
      wr_reg(32'h0000_0030, 4'hF);
      tick();

      // R3: writing 0 to status keeps it
      cur_req = "R3";
      wr_reg(32'h0000_0030, 4'hF);
      // R10: strobe on status byte off blocks the clear
      cur_req = "R10";
      wr_reg(32'h0010_0030, 4'hB);
      // R10: enable byte strobe off leaves enables
      wr_reg(32'h0000_0000, 4'h4);
      // R3: clear source 0 flag (bit 20)
      cur_req = "R3";
      wr_reg(32'h0010_0030, 4'hF);

      // R7: event and clear of the same flag in one cycle
      cur_req = "R7";
      src = 2'b10;
      wr_reg(32'h0020_0030, 4'hF);
      tick();
      // R6: held-high source, cleared, does not reassert
      cur_req = "R6";
      wr_reg(32'h0020_0030, 4'hF);
      tick(); tick();
      src = 2'b00; tick();

      // R8: all-ones write, only field bits stick
      cur_req = "R8";
      src = 2'b11; tick();
      wr_reg(32'hFFFF_FFFF & ~32'h0030_0000, 4'hF);
      tick();

      // R4: masking drops irq but keeps status
      cur_req = "R4";
      wr_reg(32'h0000_0000, 4'h1);
      tick();
      wr_reg(32'h0000_0020, 4'h1);

      // R1: other address reads zero, write there ignored
      cur_req = "R1";
      addr = 8'h1C; tick();
      wr_reg(32'hFFFF_FFFF, 4'hF);
      addr = AW'(OFS); tick();

      // R5: pseudo-random mix of events and writes
      cur_req = "R5";
      begin
         logic [15:0] lf = 16'hACE1;
         for (int k = 0; k < 300; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            src = lf[1:0];
            we  = lf[2] & lf[5];
            wd  = {lf, lf[7:0], lf[15:8]};
            be  = lf[11:8];
            tick();
         end
         idle();
      end

      // R9: reset mid-run clears everything
      cur_req = "R9";
      src = 2'b00;
      @(negedge clk); rst_n = 1'b0;
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_st[i] = 0; m_prev[i] = 0; end
      @(negedge clk); compare();
      rst_n = 1'b1;
      tick();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule